// File: doc/BRIEF.md
# ADC Conversion Status Flag Register

This block keeps the status flags of an eight-channel analog-to-digital converter controller and presents them as one read-only 32-bit word. The converter side sends a one-cycle completion pulse and the number of the channel that finished. The bus side sends one-cycle read strobes for the status word, for each channel's data register and for the last-converted-data register. A receive DMA engine supplies two level signals. Every sticky flag has its own clear-by-read source. A set event and a clear in the same cycle resolve so that no event is lost.

Overruns are found per channel and globally. A new completion on a channel whose completion flag is still set is a channel overrun. Any completion while the data-ready flag is still set is a general overrun. A read of the matching data register in the same cycle takes the old result, so it prevents the overrun. The status word is combinational from the flag registers and the DMA levels. A read therefore returns the flags as they stand before that cycle's update.

Top module: `adc_status_flags`

## Requirements
- R1: After reset all sticky flags are zero. With both DMA inputs held high, the word reads 0x000C0000.
- R2: Word layout: bits 7:0 hold the per-channel completion flags (bit n is channel n), bits 15:8 hold the per-channel overrun flags (bit 8+n is channel n), bit 16 is data-ready, bit 17 is general overrun, bit 18 is DMA end-of-receive and bit 19 is DMA buffer-full.
- R3: A completion pulse on an enabled channel sets that channel's completion flag, visible the cycle after the pulse.
- R4: A channel's completion flag clears after a read of that channel's data register or of the last-data register. A read of another channel's data register leaves it set.
- R5: A channel overrun flag sets when an enabled channel completes while its completion flag is set, unless that flag is being cleared by a read in the same cycle.
- R6: A status read returns the pre-update word and clears all channel overrun flags and the general overrun flag. A repeated read with no new events returns zero in those bits.
- R7: Data-ready sets on any enabled completion and clears after a last-data read.
- R8: General overrun sets on an enabled completion while data-ready is set and no last-data read occurs in that cycle.
- R9: When a set and a clear of the same flag occur in one cycle, the flag ends up set.
- R10: A channel with its bit of `chanEnable` low holds its completion and overrun flags at zero. Its completion pulses have no effect on any flag.
- R11: Bits 18 and 19 follow `dmaRxEnd` and `dmaBufFull` combinationally, without latching.
- R12: Bits 31:20 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEnable | input | 8 | Per-channel enable |
| convDone | input | 1 | One-cycle conversion-complete pulse |
| convChan | input | 3 | Channel of the completing conversion |
| statusRead | input | 1 | Status word read strobe |
| chanDataRead | input | 8 | Per-channel data register read strobes |
| lastDataRead | input | 1 | Last-converted-data register read strobe |
| dmaRxEnd | input | 1 | DMA end-of-receive level |
| dmaBufFull | input | 1 | DMA buffer-full level |
| statusWord | output | 32 | Status word |

## Verification
Directed sequences try a single completion, then a second completion on the same unread channel, then a completion together with a read of its own data register. These separate the plain set, the overrun and the read-consumed cases. Status reads done back to back show that the returned value is taken before the clear and that the overrun bits stay clear afterwards. A completion on a disabled channel shows that gating applies to every flag. Long random runs mix completions, all three read kinds, enable changes and DMA toggles, with a bench model as reference. These runs cover the same-cycle set and clear collisions that directed cases rarely reach.

// File: rtl/adc_status_pkg.sv
package adc_status_pkg;
  localparam int CHAN_COUNT = 8;
  localparam int CHAN_W     = $clog2(CHAN_COUNT);
  localparam int WORD_W     = 32;
  localparam int EOC_LSB    = 0;
  localparam int OVR_LSB    = CHAN_COUNT;
  localparam int DRDY_BIT   = 2 * CHAN_COUNT;
  localparam int GOVRE_BIT  = DRDY_BIT + 1;
  localparam int RXEND_BIT  = DRDY_BIT + 2;
  localparam int RXFULL_BIT = DRDY_BIT + 3;

  typedef struct packed {
    logic [CHAN_COUNT-1:0] setEoc;
    logic [CHAN_COUNT-1:0] clrEoc;
    logic [CHAN_COUNT-1:0] setOvr;
    logic [CHAN_COUNT-1:0] clrOvr;
    logic                  setDrdy;
    logic                  clrDrdy;
    logic                  setGovre;
    logic                  clrGovre;
  } flag_strb_t;
endpackage

// File: rtl/adc_status_ctrl.sv
module adc_status_ctrl
  import adc_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CHAN_COUNT-1:0] chanEnable,
  input  logic                  convDone,
  input  logic [CHAN_W-1:0]     convChan,
  input  logic                  statusRead,
  input  logic [CHAN_COUNT-1:0] chanDataRead,
  input  logic                  lastDataRead,
  input  logic [CHAN_COUNT-1:0] eocQ,
  input  logic                  drdyQ,
  output flag_strb_t            strb
);
  logic [CHAN_COUNT-1:0] doneVec;
  logic [CHAN_COUNT-1:0] readClr;
  logic                  validDone;

  always_comb begin
    validDone = convDone && chanEnable[convChan];
    doneVec   = validDone ? (CHAN_COUNT'(1) << convChan) : '0;
    readClr   = chanDataRead | {CHAN_COUNT{lastDataRead}};

    strb.setEoc   = doneVec;
    strb.clrEoc   = readClr | ~chanEnable;
    strb.setOvr   = doneVec & eocQ & ~readClr;
    strb.clrOvr   = {CHAN_COUNT{statusRead}} | ~chanEnable;
    strb.setDrdy  = validDone;
    strb.clrDrdy  = lastDataRead;
    strb.setGovre = validDone && drdyQ && !lastDataRead;
    strb.clrGovre = statusRead;
  end

  // R3: at most one channel completes per cycle
  p_one_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.setEoc));

  // R10: disabled channels never see a set strobe
  p_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setEoc & ~chanEnable) == '0);
endmodule

// File: rtl/adc_status_regs.sv
module adc_status_regs
  import adc_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  flag_strb_t            strb,
  output logic [CHAN_COUNT-1:0] eocQ,
  output logic [CHAN_COUNT-1:0] ovrQ,
  output logic                  drdyQ,
  output logic                  govreQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eocQ   <= '0;
      ovrQ   <= '0;
      drdyQ  <= 1'b0;
      govreQ <= 1'b0;
    end else begin
      eocQ   <= (eocQ & ~strb.clrEoc) | strb.setEoc;
      ovrQ   <= (ovrQ & ~strb.clrOvr) | strb.setOvr;
      drdyQ  <= (drdyQ & ~strb.clrDrdy) | strb.setDrdy;
      govreQ <= (govreQ & ~strb.clrGovre) | strb.setGovre;
    end
  end

  for (genvar i = 0; i < CHAN_COUNT; i++) begin : g_chk
    // R9: a set always survives a same-cycle clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      strb.setEoc[i] |=> eocQ[i]);
    // R6: status read empties an overrun flag unless re-set
    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrOvr[i] && !strb.setOvr[i]) |=> !ovrQ[i]);
    // R5: a new overrun implies the channel was already complete
    p_ovr_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovrQ[i]) |-> $past(eocQ[i]));
  end

  // R7: data-ready follows a valid completion
  p_drdy_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDrdy |=> drdyQ);
  // R8: general overrun only rises while data-ready was pending
  p_govre_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(govreQ) |-> $past(drdyQ));
endmodule

// File: rtl/adc_status_flags.sv
module adc_status_flags
  import adc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        chanEnable,
  input  logic              convDone,
  input  logic [2:0]        convChan,
  input  logic              statusRead,
  input  logic [7:0]        chanDataRead,
  input  logic              lastDataRead,
  input  logic              dmaRxEnd,
  input  logic              dmaBufFull,
  output logic [31:0]       statusWord
);
  flag_strb_t            strb;
  logic [CHAN_COUNT-1:0] eocQ;
  logic [CHAN_COUNT-1:0] ovrQ;
  logic                  drdyQ;
  logic                  govreQ;

  adc_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .convDone(convDone),
    .convChan(convChan), .statusRead(statusRead), .chanDataRead(chanDataRead),
    .lastDataRead(lastDataRead), .eocQ(eocQ), .drdyQ(drdyQ), .strb(strb)
  );

  adc_status_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .eocQ(eocQ), .ovrQ(ovrQ),
    .drdyQ(drdyQ), .govreQ(govreQ)
  );

  always_comb begin
    statusWord = '0;
    statusWord[EOC_LSB +: CHAN_COUNT] = eocQ;
    statusWord[OVR_LSB +: CHAN_COUNT] = ovrQ;
    statusWord[DRDY_BIT]   = drdyQ;
    statusWord[GOVRE_BIT]  = govreQ;
    statusWord[RXEND_BIT]  = dmaRxEnd;
    statusWord[RXFULL_BIT] = dmaBufFull;
  end

  // R4: a last-data read with no completion leaves no completion flag set
  p_last_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lastDataRead && !convDone) |=> (eocQ == '0 && !drdyQ));
endmodule

// File: tb/adc_status_flags_bench.sv
`timescale 1ns/1ps
module adc_status_flags_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  chanEnable;
  logic        convDone;
  logic [2:0]  convChan;
  logic        statusRead;
  logic [7:0]  chanDataRead;
  logic        lastDataRead;
  logic        dmaRxEnd;
  logic        dmaBufFull;
  logic [31:0] statusWord;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [7:0] mEoc, mOvr;
  logic       mDrdy, mGovre;

  always #2.5 clk = ~clk;

  adc_status_flags u_adc_status_flags (
    .clk(clk), .rstN(rstN), .chanEnable(chanEnable), .convDone(convDone),
    .convChan(convChan), .statusRead(statusRead), .chanDataRead(chanDataRead),
    .lastDataRead(lastDataRead), .dmaRxEnd(dmaRxEnd), .dmaBufFull(dmaBufFull),
    .statusWord(statusWord)
  );

  function automatic logic [31:0] modelWord(input logic rxE, input logic bf);
    return {12'h000, bf, rxE, mGovre, mDrdy, mOvr, mEoc};
  endfunction

  task automatic modelStep();
    logic [7:0] doneV, rdClr;
    logic       vd;
    vd    = convDone && chanEnable[convChan];
    doneV = vd ? (8'd1 << convChan) : 8'd0;
    rdClr = chanDataRead | {8{lastDataRead}};
    mOvr   = (mOvr & ~({8{statusRead}} | ~chanEnable)) | (doneV & mEoc & ~rdClr);
    mGovre = (mGovre & ~statusRead) | (vd & mDrdy & ~lastDataRead);
    mEoc   = (mEoc & ~(rdClr | ~chanEnable)) | doneV;
    mDrdy  = (mDrdy & ~lastDataRead) | vd;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive one cycle; check the word (pre-edge) against the model and an optional constant
  task automatic cyc(input logic d, input logic [2:0] ch, input logic sr,
                     input logic [7:0] cr, input logic lr, input logic [7:0] en,
                     input logic rxE, input logic bf,
                     input bit useExp, input logic [31:0] exp, input string tag);
    @(negedge clk);
    convDone = d; convChan = ch; statusRead = sr; chanDataRead = cr;
    lastDataRead = lr; chanEnable = en; dmaRxEnd = rxE; dmaBufFull = bf;
    #1;
    if (useExp) check(statusWord, exp, tag);
    else check(statusWord, modelWord(rxE, bf), tag);
    modelStep();
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; convDone = 0; convChan = 0; statusRead = 0; chanDataRead = 0;
    lastDataRead = 0; chanEnable = 8'hFF; dmaRxEnd = 1; dmaBufFull = 1;
    mEoc = 0; mOvr = 0; mDrdy = 0; mGovre = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1 check(statusWord, 32'h000C0000, "R1 reset word");

    cyc(0,0,0,0,0,8'hFF,0,0, 1, 32'h0, "R11 dma low");
    cyc(1,3,0,0,0,8'hFF,1,0, 1, 32'h00040000, "R11 rx end only");
    cyc(0,0,0,0,0,8'hFF,0,0, 1, 32'h00010008, "R3 eoc3 and R7 drdy");
    cyc(1,3,0,0,0,8'hFF,0,0, 1, 32'h00010008, "R2 layout");
    cyc(0,0,0,0,0,8'hFF,0,0, 1, 32'h00030808, "R5 ovr3 and R8 govre");
    cyc(0,0,1,0,0,8'hFF,0,0, 1, 32'h00030808, "R6 read returns pre-clear");
    cyc(0,0,1,0,0,8'hFF,0,0, 1, 32'h00010008, "R6 overruns cleared");
    cyc(0,0,0,8'h01,0,8'hFF,0,0, 1, 32'h00010008, "R4 other channel read");
    cyc(0,0,0,8'h08,0,8'hFF,0,0, 1, 32'h00010008, "R4 still set");
    cyc(0,0,0,0,1,8'hFF,0,0, 1, 32'h00010000, "R4 channel read cleared eoc3");
    cyc(1,5,0,0,0,8'hFF,0,0, 1, 32'h0, "R7 last read cleared drdy");
    cyc(1,5,0,8'h20,0,8'hFF,0,0, 1, 32'h00010020, "R9 pre collision");
    cyc(0,0,1,0,1,8'hFF,0,0, 1, 32'h00030020, "R9 set wins, R5 read consumed");
    cyc(1,2,0,0,0,8'hFB,0,0, 1, 32'h0, "R4 last read clears all");
    cyc(0,0,1,0,0,8'hFB,0,0, 1, 32'h0, "R10 disabled channel ignored");
    cyc(0,0,0,0,0,8'hFF,0,0, 1, 32'h0, "R6 repeated read zero");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] en;
      logic [7:0] cr;
      en = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'hFF;
      cr = ($urandom_range(0, 5) == 0) ? (8'd1 << $urandom_range(0, 7)) : 8'd0;
      cyc(1'($urandom_range(0, 2) != 0), 3'($urandom), 1'($urandom_range(0, 5) == 0),
          cr, 1'($urandom_range(0, 6) == 0), en, 1'($urandom), 1'($urandom),
          0, 32'h0, "R9 random model");
      if (statusWord[31:20] != 12'h0) check(statusWord, statusWord & 32'h000FFFFF, "R12 upper zero");
    end
    testsRun++;
    if (statusWord[31:20] != 12'h0) begin
      testsFailed++;
      $display("FAIL R12: actual %03h expected 000", statusWord[31:20]);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule